// File: doc/BRIEF.md
# Serial Slave Front End with Transfer Pause

This block is the serial-link edge of a register-based peripheral. A host drives a serial clock, a data line and an active-low select. The block oversamples all of them in a faster system clock. It shifts received bits into bytes, most significant bit first, and hands each finished byte to the command layer. Each byte comes with its position in the frame and a flag that marks the first byte. In the other direction it shifts out a byte that the command layer supplies, through an output that has a separate enable so that a pad can tri-state it.

Clock modes 0 and 3 are both supported with no mode setting. Input is taken on the rising serial clock edge and output moves on the falling edge. In mode 3 the clock idles high, so the block skips the falling edge that comes before the first rising edge of a frame. An active-low pause input lets the host stop a transfer part-way through a byte and continue it later. While the link is paused the output is released and the data line is ignored.

Raising the select signal reports an end-of-frame event. The command layer uses that event to start its commit work. Decoding of commands and storage of registers sit outside the block.

The controller has three states. `ST_IDLE` means the select is high. `ST_RUN` means a frame is open and clock edges are being processed. `ST_HOLD` means the frame is paused. The transitions are:
- `ST_IDLE` to `ST_RUN` when the select goes low (frame open).
- `ST_RUN` to `ST_HOLD` when pause and serial clock are both low (pause).
- `ST_HOLD` to `ST_RUN` when pause is high while the serial clock is low (resume).
- `ST_RUN` or `ST_HOLD` to `ST_IDLE` when the select goes high (frame close, with the end event).

Top module: `serial_hold_slave`

## Requirements
- R1: The serial data is sampled on each rising edge of the serial clock and shifted in most significant bit first. After the eighth bit, `rx_valid_o` is high for exactly one system clock and `rx_data_o` holds the byte.
- R2: Each delivered byte carries `rx_index_o`. It is 0 for the first byte of a frame and goes up by one for each later byte, modulo 2^IDX_W. `rx_sof_o` is 1 only on the first byte of a frame.
- R3: The serial output changes only after falling serial clock edges. The first byte of a frame is the value of `tx_data_i` taken when the frame opens. Each later byte is taken from `tx_data_i` at the first falling edge after the last rising edge of the previous byte. Each byte is sent most significant bit first.
- R4: Modes 0 (clock idles low) and 3 (clock idles high) both work with no configuration. A falling edge that comes before the first rising edge of a frame does not shift the output.
- R5: While the select is high, `sdo_en_o` is 0, `rx_valid_o` stays 0 and serial clock edges have no effect.
- R6: A falling select edge opens a new frame. It clears the bit position and the byte index.
- R7: A pause starts only when the pause input and the serial clock are both seen low. It ends only when the pause input is seen high while the serial clock is low.
- R8: While paused, `sdo_en_o` is 0 and serial clock and data edges are ignored. After the pause ends, the frame continues from the same bit position and the same output bit.
- R9: A rising select edge from an open or paused frame raises `frame_end_o` for one system clock. `sdo_en_o` is 0 in that cycle.
- R10: A frame that closes part-way through a byte delivers no byte for those bits.
- R11: Each serial input passes through two synchroniser flops before edge detection. This sets the response latency. The serial clock must be at most one quarter of the system clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| csn_i | input | 1 | Active-low frame select |
| holdn_i | input | 1 | Active-low transfer pause |
| sdo_o | output | 1 | Serial data to host |
| sdo_en_o | output | 1 | Drive enable for the serial output pad |
| tx_data_i | input | DATA_W | Byte to send next, from the command layer |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_index_o | output | IDX_W | Position of the byte in the frame |
| rx_sof_o | output | 1 | First byte of the frame |
| frame_end_o | output | 1 | One-cycle pulse when the select rises |

## Verification
The bench aims at these corner cases:
- **Pause inside a byte.** A stray clock pulse and flipped data are applied while paused. A design that counted edges during the pause would return a shifted byte.
- **Mode 3 start.** The clock idles high, so the first edge of a frame is a falling one. A design that shifted on it would lose the top output bit.
- **Next-byte load point.** A design that loaded the next output byte at the wrong falling edge would corrupt every byte after the first.
- **Partial frame, then a fresh frame.** A three-bit frame is followed by a full frame. A design that did not discard partial bits, or did not clear the index, would report a stray byte or a non-zero first index.

// File: rtl/sph_pkg.sv
package sph_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } link_state_t;
endpackage

// File: rtl/sph_sync.sv
module sph_sync #(
    parameter int            W       = 4,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sph_ctrl.sv
module sph_ctrl
    import sph_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csn_s,
    input  logic        holdn_s,
    input  logic        sck_s,
    output link_state_t state,
    output logic        frame_open,
    output logic        edge_en,
    output logic        frame_end
);
    link_state_t nxt;
    logic        close_evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            frame_end <= 1'b0;
        end else begin
            state     <= nxt;
            frame_end <= close_evt;
        end
    end

    // next state and outputs
    always_comb begin
        nxt        = state;
        frame_open = 1'b0;
        edge_en    = 1'b0;
        close_evt  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!csn_s) begin
                    nxt        = ST_RUN;
                    frame_open = 1'b1;
                end
            end
            ST_RUN: begin
                if (csn_s) begin
                    nxt       = ST_IDLE;
                    close_evt = 1'b1;
                end else begin
                    edge_en = 1'b1;
                    if (!holdn_s && !sck_s) nxt = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (csn_s) begin
                    nxt       = ST_IDLE;
                    close_evt = 1'b1;
                end else if (holdn_s && !sck_s) begin
                    nxt = ST_RUN;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/sph_shift.sv
module sph_shift #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_open,
    input  logic              edge_en,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic [IDX_W-1:0]  rx_index,
    output logic              rx_sof,
    output logic              tx_bit
);
    localparam int                CNT_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              drive_pend;
    logic              first;
    logic [DATA_W-1:0] rx_next;

    assign rx_next = {rx_sh[DATA_W-2:0], sdi};
    assign tx_bit  = tx_sh[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            idx        <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            drive_pend <= 1'b0;
            first      <= 1'b0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_index   <= '0;
            rx_sof     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (frame_open) begin
                bit_cnt    <= '0;
                idx        <= '0;
                drive_pend <= 1'b0;
                first      <= 1'b1;
                tx_sh      <= tx_data;
            end else if (edge_en) begin
                if (rise) begin
                    rx_sh      <= rx_next;
                    drive_pend <= 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt  <= '0;
                        rx_data  <= rx_next;
                        rx_valid <= 1'b1;
                        rx_index <= idx;
                        rx_sof   <= first;
                        first    <= 1'b0;
                        idx      <= idx + 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (fall && drive_pend) begin
                    drive_pend <= 1'b0;
                    if (bit_cnt == '0) tx_sh <= tx_data;
                    else               tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/serial_hold_slave.sv
module serial_hold_slave
    import sph_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int IDX_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              csn_i,
    input  logic              holdn_i,
    output logic              sdo_o,
    output logic              sdo_en_o,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic [IDX_W-1:0]  rx_index_o,
    output logic              rx_sof_o,
    output logic              frame_end_o
);
    localparam int         N_IN     = 4;
    localparam logic [3:0] SYNC_RST = 4'b0011; // sck, sdi low; csn, holdn high

    logic [N_IN-1:0] sync_q;
    logic            sck_s, sdi_s, csn_s, holdn_s, sck_d;
    logic            rise, fall;
    link_state_t     state;
    logic            frame_open, edge_en;

    sph_sync #(.W(N_IN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, sdi_i, csn_i, holdn_i}),
        .q     (sync_q)
    );

    assign {sck_s, sdi_s, csn_s, holdn_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign rise = sck_s & ~sck_d;
    assign fall = ~sck_s & sck_d;

    sph_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .csn_s      (csn_s),
        .holdn_s    (holdn_s),
        .sck_s      (sck_s),
        .state      (state),
        .frame_open (frame_open),
        .edge_en    (edge_en),
        .frame_end  (frame_end_o)
    );

    sph_shift #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_open (frame_open),
        .edge_en    (edge_en),
        .rise       (rise),
        .fall       (fall),
        .sdi        (sdi_s),
        .tx_data    (tx_data_i),
        .rx_data    (rx_data_o),
        .rx_valid   (rx_valid_o),
        .rx_index   (rx_index_o),
        .rx_sof     (rx_sof_o),
        .tx_bit     (sdo_o)
    );

    assign sdo_en_o = (state == ST_RUN);
endmodule

// File: rtl/sph_checker.sv
module sph_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sck_i,
    input logic             csn_i,
    input logic             holdn_i,
    input logic             sdo_en_o,
    input logic             rx_valid_o,
    input logic [IDX_W-1:0] rx_index_o,
    input logic             rx_sof_o,
    input logic             frame_end_o
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o); // R1

    AST_SOF_ZERO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && rx_sof_o) |-> (rx_index_o == '0)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(csn_i, 1) && $past(csn_i, 2) && $past(csn_i, 3))
        |-> (!sdo_en_o && !rx_valid_o)); // R5

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(holdn_i, 1) && !$past(holdn_i, 2) && !$past(holdn_i, 3) && !$past(holdn_i, 4) &&
         !$past(sck_i, 1) && !$past(sck_i, 2) && !$past(sck_i, 3) && !$past(sck_i, 4) &&
         !$past(csn_i, 1) && !$past(csn_i, 2) && !$past(csn_i, 3) && !$past(csn_i, 4))
        |-> !sdo_en_o); // R8

    AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |-> (!sdo_en_o && $past(csn_i, 2))); // R9

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> !frame_end_o); // R9
endmodule

bind serial_hold_slave sph_checker #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_i       (sck_i),
    .csn_i       (csn_i),
    .holdn_i     (holdn_i),
    .sdo_en_o    (sdo_en_o),
    .rx_valid_o  (rx_valid_o),
    .rx_index_o  (rx_index_o),
    .rx_sof_o    (rx_sof_o),
    .frame_end_o (frame_end_o)
);

// File: tb/sim_serial_hold_slave.sv
module sim_serial_hold_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 8;   // system clocks per serial half period
    localparam int DW         = 8;
    localparam int IW         = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck_i = 1'b0, sdi_i = 1'b0, csn_i = 1'b1, holdn_i = 1'b1;
    logic [DW-1:0] tx_data_i = '0;
    logic sdo_o, sdo_en_o, rx_valid_o, rx_sof_o, frame_end_o;
    logic [DW-1:0] rx_data_o;
    logic [IW-1:0] rx_index_o;

    serial_hold_slave #(.DATA_W(DW), .IDX_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .sdi_i(sdi_i), .csn_i(csn_i),
        .holdn_i(holdn_i), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o), .tx_data_i(tx_data_i),
        .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_index_o(rx_index_o),
        .rx_sof_o(rx_sof_o), .frame_end_o(frame_end_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0, checks = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // R11: inputs seen two clocks late; clock edge from the last two seen values
    bit h_sck[4], h_sdi[4], h_csn[4], h_hold[4];
    int m_st, m_bits, m_idx, m_rx, m_tx;
    bit m_pend, m_first, live;
    bit e_valid, e_end, e_sof;
    int e_data, e_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin
                h_sck[k] = 0; h_sdi[k] = 0; h_csn[k] = 1; h_hold[k] = 1;
            end
            m_st = 0; m_bits = 0; m_idx = 0; m_rx = 0; m_tx = 0;
            m_pend = 0; m_first = 0; live = 0; e_valid = 0; e_end = 0;
        end else begin
            bit cs, sk, pk, rs, fl;
            for (int k = 3; k > 0; k--) begin
                h_sck[k] = h_sck[k-1]; h_sdi[k] = h_sdi[k-1];
                h_csn[k] = h_csn[k-1]; h_hold[k] = h_hold[k-1];
            end
            h_sck[0] = sck_i; h_sdi[0] = sdi_i; h_csn[0] = csn_i; h_hold[0] = holdn_i;
            live = 1;
            cs = h_csn[2]; sk = h_sck[2]; pk = h_sck[3];
            rs = sk && !pk; fl = !sk && pk;
            e_valid = 0; e_end = 0;
            if (m_st == 1 && !cs) begin
                if (rs) begin
                    m_rx = ((m_rx << 1) | int'(h_sdi[2])) & 255;
                    m_bits++; m_pend = 1;
                    if (m_bits == 8) begin
                        m_bits = 0; e_valid = 1; e_data = m_rx;
                        e_idx = m_idx % 16; e_sof = m_first; m_first = 0; m_idx++;
                    end
                end
                if (fl && m_pend) begin
                    m_pend = 0;
                    if (m_bits == 0) m_tx = int'(tx_data_i);
                    else             m_tx = (m_tx << 1) & 255;
                end
            end
            if (m_st == 0) begin
                if (!cs) begin
                    m_st = 1; m_bits = 0; m_idx = 0; m_pend = 0; m_first = 1;
                    m_tx = int'(tx_data_i);
                end
            end else if (cs) begin
                e_end = 1; m_st = 0;
            end else if (m_st == 1 && !h_hold[2] && !sk) m_st = 2;
            else if (m_st == 2 && h_hold[2] && !sk) m_st = 1;
        end
    end

    // per-clock comparison, away from the active edge
    int got_data[$], got_idx[$], got_sof[$];
    int end_count = 0;

    always @(negedge clk) begin
        if (live) begin
            check(sdo_en_o == (m_st == 1), "R5/R8 sdo_en_o vs model", sdo_en_o, m_st == 1);
            if (sdo_en_o) check(sdo_o == m_tx[7], "R3 sdo_o vs model", sdo_o, m_tx[7]);
            check(rx_valid_o == e_valid, "R1 rx_valid_o vs model", rx_valid_o, e_valid);
            if (e_valid && rx_valid_o) begin
                check(rx_data_o == e_data[7:0], "R1 rx_data_o vs model", rx_data_o, e_data);
                check(rx_index_o == e_idx[3:0], "R2 rx_index_o vs model", rx_index_o, e_idx);
                check(rx_sof_o == e_sof, "R2 rx_sof_o vs model", rx_sof_o, e_sof);
            end
            check(frame_end_o == e_end, "R9 frame_end_o vs model", frame_end_o, e_end);
        end
        if (rx_valid_o) begin
            got_data.push_back(rx_data_o);
            got_idx.push_back(rx_index_o);
            got_sof.push_back(rx_sof_o);
        end
        if (frame_end_o) end_count++;
    end

    // ---------------- host driver ----------------
    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_frame(input bit mode3);
        sck_i = mode3;
        wait_clk(HALF_SCK);
        csn_i = 1'b0;
        wait_clk(HALF_SCK);
    endtask

    task automatic close_frame();
        wait_clk(HALF_SCK);
        csn_i = 1'b1;
        wait_clk(HALF_SCK);
        sck_i = 1'b0;
        wait_clk(HALF_SCK);
    endtask

    task automatic pause_here(input bit with_glitch);
        holdn_i = 1'b0;
        wait_clk(HALF_SCK);
        check(sdo_en_o == 1'b0, "R8 output released while paused", sdo_en_o, 0);
        sdi_i = ~sdi_i;
        if (with_glitch) begin
            sck_i = 1'b1; wait_clk(4); sck_i = 1'b0;
        end
        wait_clk(HALF_SCK);
        holdn_i = 1'b1;
        wait_clk(HALF_SCK);
    endtask

    task automatic xfer(input bit mode3, input int nbits, input logic [7:0] mosi,
                        input logic [7:0] next_tx, input int pause_after,
                        output logic [7:0] miso);
        miso = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            if (mode3) sck_i = 1'b0;
            sdi_i = mosi[i];
            wait_clk(HALF_SCK);
            sck_i = 1'b1;
            miso[i] = sdo_o;
            if (i == 0) begin
                wait_clk(4);
                tx_data_i = next_tx;
                wait_clk(HALF_SCK - 4);
            end else begin
                wait_clk(HALF_SCK);
            end
            if (!mode3) sck_i = 1'b0;
            if (i == pause_after) begin
                wait_clk(1);
                pause_here(1'b1);
            end
        end
    endtask

    task automatic clear_log();
        got_data.delete(); got_idx.delete(); got_sof.delete(); end_count = 0;
    endtask

    task automatic check_byte(input int n, input int data, input int idx, input bit sof,
                              input string tag);
        if (got_data.size() > n) begin
            check(got_data[n] == data, tag, got_data[n], data);
            check(got_idx[n] == idx, "R2 byte index", got_idx[n], idx);
            check(got_sof[n] == sof, "R2 start-of-frame flag", got_sof[n], sof);
        end else check(0, {tag, " missing byte"}, got_data.size(), n + 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R11 watchdog act=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] miso;
        wait_clk(5);
        check(sdo_en_o == 0, "R5 reset sdo_en_o", sdo_en_o, 0);
        check(rx_valid_o == 0, "R5 reset rx_valid_o", rx_valid_o, 0);
        check(frame_end_o == 0, "R9 reset frame_end_o", frame_end_o, 0);
        rst_n = 1'b1;
        wait_clk(10);

        // R5: clock edges with select high do nothing
        clear_log();
        for (int k = 0; k < 4; k++) begin
            sck_i = 1'b1; wait_clk(HALF_SCK); sck_i = 1'b0; wait_clk(HALF_SCK);
        end
        check(got_data.size() == 0, "R5 no byte while deselected", got_data.size(), 0);
        check(sdo_en_o == 0, "R5 output released while deselected", sdo_en_o, 0);

        // R1/R2/R3 mode 0, three bytes
        clear_log();
        tx_data_i = 8'h96;
        open_frame(1'b0);
        xfer(1'b0, 8, 8'hA5, 8'h0F, -1, miso);
        check(miso == 8'h96, "R3 mode0 out byte 0", miso, 8'h96);
        xfer(1'b0, 8, 8'h3C, 8'hE1, -1, miso);
        check(miso == 8'h0F, "R3 mode0 out byte 1", miso, 8'h0F);
        xfer(1'b0, 8, 8'hFF, 8'h00, -1, miso);
        check(miso == 8'hE1, "R3 mode0 out byte 2", miso, 8'hE1);
        close_frame();
        check_byte(0, 8'hA5, 0, 1, "R1 mode0 in byte 0");
        check_byte(1, 8'h3C, 1, 0, "R1 mode0 in byte 1");
        check_byte(2, 8'hFF, 2, 0, "R1 mode0 in byte 2");
        check(end_count == 1, "R9 one end event", end_count, 1);

        // R4 mode 3, two bytes
        clear_log();
        tx_data_i = 8'hC3;
        open_frame(1'b1);
        xfer(1'b1, 8, 8'h81, 8'h5A, -1, miso);
        check(miso == 8'hC3, "R4 mode3 out byte 0", miso, 8'hC3);
        xfer(1'b1, 8, 8'h7E, 8'h00, -1, miso);
        check(miso == 8'h5A, "R4 mode3 out byte 1", miso, 8'h5A);
        close_frame();
        check_byte(0, 8'h81, 0, 1, "R4 mode3 in byte 0");
        check_byte(1, 8'h7E, 1, 0, "R4 mode3 in byte 1");

        // R10 partial frame, then R6 fresh frame restarts framing
        clear_log();
        tx_data_i = 8'hFF;
        open_frame(1'b0);
        xfer(1'b0, 3, 8'hE0, 8'h00, -1, miso);
        close_frame();
        check(got_data.size() == 0, "R10 partial byte discarded", got_data.size(), 0);
        check(end_count == 1, "R9 end event after partial frame", end_count, 1);
        clear_log();
        tx_data_i = 8'h24;
        open_frame(1'b0);
        xfer(1'b0, 8, 8'h4B, 8'h00, -1, miso);
        close_frame();
        check(miso == 8'h24, "R6 first out byte after restart", miso, 8'h24);
        check_byte(0, 8'h4B, 0, 1, "R6 byte after restart");

        // R7/R8 pause in the middle of a byte, with glitches on SI and SCK
        clear_log();
        tx_data_i = 8'hB2;
        open_frame(1'b0);
        xfer(1'b0, 8, 8'h6D, 8'h19, 4, miso);
        check(miso == 8'hB2, "R8 out byte across pause", miso, 8'hB2);
        xfer(1'b0, 8, 8'h92, 8'h00, 7, miso);
        check(miso == 8'h19, "R8 out byte after pause", miso, 8'h19);
        close_frame();
        check_byte(0, 8'h6D, 0, 1, "R8 in byte across pause");
        check_byte(1, 8'h92, 1, 0, "R8 in byte after pause");

        // R7 pause low while SCK high does not pause until SCK falls
        clear_log();
        tx_data_i = 8'h55;
        open_frame(1'b0);
        sdi_i = 1'b1; wait_clk(HALF_SCK);
        sck_i = 1'b1; wait_clk(2);
        holdn_i = 1'b0; wait_clk(HALF_SCK - 2);
        check(sdo_en_o == 1, "R7 no pause while SCK high", sdo_en_o, 1);
        sck_i = 1'b0; wait_clk(HALF_SCK);
        check(sdo_en_o == 0, "R7 pause once SCK low", sdo_en_o, 0);
        holdn_i = 1'b1; wait_clk(HALF_SCK);
        check(sdo_en_o == 1, "R7 resume with SCK low", sdo_en_o, 1);
        close_frame();
        check(end_count == 1, "R9 end event after pause test", end_count, 1);

        wait_clk(10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule